// File: doc/BRIEF.md
# Triangle Setup Engine

This block turns three screen-space vertices into the per-triangle values a scanline rasterizer uses to walk a triangle. Each vertex carries position (x, y), depth z and colour r, g, b. The vertices arrive already sorted by y. From them the block derives:

- the x slope of each of the three edges;
- the z, r, g and b slopes along the edge that spans the full height;
- the height ratio Q of the middle vertex;
- four horizontal gradients.

One pipelined divider (32-cycle latency, one issue per clock) and one pipelined multiplier (1-cycle latency) do all of the arithmetic. They follow a fixed 16-cycle schedule. Inside each schedule slot the engine serves five triangles, each at a different age. Each triangle's operands and partial results ride along a five-entry shift register that advances at every slot boundary.

An upstream producer presents a triangle with `in_valid`. The triangle is taken in the one cycle per slot in which `in_ready` is high. The finished set of twelve values appears on a one-cycle `out_valid` pulse five slots later. Slots with no accepted triangle travel through the pipe as empty entries.

Top module: `tri_setup`

## Requirements
- R1: `in_ready` is high only in the last cycle of each 16-cycle slot, counted from reset release. A triangle is taken when `in_valid` and `in_ready` are both high at a clock edge. At most one triangle is taken per slot.
- R2: All values are signed 16.16 two's complement, 32 bits wide, and differences wrap modulo 2^32. In `in_vtx`, vertex k (0..2) field f sits at bits [(6k+f)*32 +: 32], with f = 0 x, 1 y, 2 z, 3 r, 4 g, 5 b. In `out_res`, result i sits at bits [32i +: 32] in this order: 0 Q, 1 long-edge x slope, 2 upper-edge x slope, 3 lower-edge x slope, 4..7 z/r/g/b long-edge slopes, 8..11 z/r/g/b horizontal gradients.
- R3: Result 1 is (x2-x0)/(y2-y0). Result 2 is (x1-x0)/(y1-y0). Result 3 is (x2-x1)/(y2-y1).
- R4: Result 0 is Q = (y1-y0)/(y2-y0). Results 4..7 are (c2-c0)/(y2-y0) for c in z, r, g, b.
- R5: Let P(d) = floor(d*Q / 2^16), keeping the low 32 bits. The shared denominator is D = x1-x0-P(x2-x0). Results 8..11 are (c1-c0-P(c2-c0))/D for c in z, r, g, b, where Q is result 0 as produced.
- R6: A quotient is (dividend*2^16)/divisor rounded toward zero. A quotient outside the 32-bit signed range is clamped to 0x7FFFFFFF or 0x80000000 by its sign, and does not set an error bit.
- R7: A zero divisor gives 0x7FFFFFFF for a dividend of zero or more, and 0x80000000 for a negative one. It also sets `out_err` bit i for that result.
- R8: A triangle taken in cycle t is presented with `out_valid` high for exactly the single cycle t+77.
- R9: Triangles may be taken in every slot back to back, and each one produces exactly one output pulse, in order of arrival.
- R10: A slot in which no triangle is taken produces no `out_valid` pulse. Input data offered while `in_ready` is low has no effect on any output.
- R11: While reset is asserted, `out_valid` and `in_ready` are low. After release, `in_ready` stays low for the first 15 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A triangle is offered on `in_vtx` |
| in_ready | output | 1 | The engine takes a triangle at this edge |
| in_vtx | input | 576 | Three vertices of six 16.16 fields |
| out_valid | output | 1 | `out_res` and `out_err` hold a finished triangle |
| out_res | output | 384 | Twelve 16.16 results |
| out_err | output | 12 | Divide-by-zero flag for each result |

## Verification
The shared divider both issues and retires in the same cycle. In cycle 0 of each slot, the Q division for the newest triangle enters the divider while the Q quotient of the triangle two slots older leaves it. In cycles 8 to 11, the gradient divisions of one triangle enter while those of the triangle two slots older return. The bench provokes this by offering triangles in four of every five slots back to back. It compares every returned value against a behavioural model, so a result written to the wrong age or index shows up as a mismatch. Hand-picked triangles add zero heights, collinear vertices, a quotient that overflows and a small negative quotient, which exercise the flag and rounding rules.

// File: rtl/tri_setup.sv
module tri_setup #(
  parameter int W       = 32,
  parameter int FRAC    = 16,
  parameter int SLOT    = 16,
  parameter int DIV_LAT = 32,
  parameter int DEPTH   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [18*W-1:0]   in_vtx,
  output logic              out_valid,
  output logic [12*W-1:0]   out_res,
  output logic [11:0]       out_err
);
  localparam int NV   = 18;
  localparam int NR   = 12;
  localparam int CW   = $clog2(SLOT);
  localparam int MID  = 2;
  localparam int OLD  = DEPTH - 1;
  localparam int EMIT = 12;
  localparam logic [CW-1:0] LAST = CW'(SLOT - 1);

  logic [CW-1:0]       cyc;
  logic                vld [DEPTH];
  logic signed [W-1:0] vtx [DEPTH][NV];
  logic signed [W-1:0] res [DEPTH][NR];
  logic [NR-1:0]       err [DEPTH];
  logic signed [W-1:0] den [DEPTH];
  logic signed [W-1:0] num [DEPTH][4];
  logic signed [W-1:0] div_a, div_b, mul_a, mul_q, diff;
  logic [W:0]          dpipe [DIV_LAT];

  function automatic logic [W:0] fx_div(input logic signed [W-1:0] a, input logic signed [W-1:0] b);
    logic signed [2*W-1:0] n, d, q;
    if (b == '0) return {1'b1, a[W-1], {(W-1){~a[W-1]}}};
    n = {{W{a[W-1]}}, a};
    n = n <<< FRAC;
    d = {{W{b[W-1]}}, b};
    q = n / d;
    if (q[2*W-1:W-1] != {(W+1){q[2*W-1]}}) return {1'b0, q[2*W-1], {(W-1){~q[2*W-1]}}};
    return {1'b0, q[W-1:0]};
  endfunction

  function automatic logic signed [W-1:0] fx_mul(input logic signed [W-1:0] a, input logic signed [W-1:0] b);
    logic [2*W-1:0] p;
    p = {{W{a[W-1]}}, a} * {{W{b[W-1]}}, b};
    return p[W+FRAC-1:FRAC];
  endfunction

  assign in_ready  = (cyc == LAST);
  assign out_valid = vld[OLD] && (cyc == CW'(EMIT));
  assign out_err   = err[OLD];
  for (genvar i = 0; i < NR; i++) begin : g_out
    assign out_res[i*W +: W] = res[OLD][i];
  end

  always_comb begin
    div_a = '0;
    div_b = W'(1);
    mul_a = '0;
    diff  = '0;
    if (cyc == CW'(0)) begin div_a = vtx[0][7]  - vtx[0][1]; div_b = vtx[0][13] - vtx[0][1]; end
    if (cyc == CW'(1)) begin div_a = vtx[0][12] - vtx[0][0]; div_b = vtx[0][13] - vtx[0][1]; end
    if (cyc == CW'(2)) begin div_a = vtx[0][6]  - vtx[0][0]; div_b = vtx[0][7]  - vtx[0][1]; end
    if (cyc == CW'(3)) begin div_a = vtx[0][12] - vtx[0][6]; div_b = vtx[0][13] - vtx[0][7]; end
    for (int f = 2; f < 6; f++)
      if (cyc == CW'(f + 2)) begin div_a = vtx[0][12+f] - vtx[0][f]; div_b = vtx[0][13] - vtx[0][1]; end
    for (int j = 0; j < 4; j++)
      if (cyc == CW'(8 + j)) begin div_a = num[MID][j]; div_b = den[MID]; end
    for (int f = 0; f < 6; f++)
      if (f != 1 && cyc == CW'(f == 0 ? 1 : f)) mul_a = vtx[MID][12+f] - vtx[MID][f];
    for (int f = 0; f < 6; f++)
      if (f != 1 && cyc == CW'(f == 0 ? 2 : f + 1)) diff = vtx[MID][6+f] - vtx[MID][f] - mul_q;
  end

  always_ff @(posedge clk) begin
    mul_q    <= fx_mul(mul_a, res[MID][0]);
    dpipe[0] <= fx_div(div_a, div_b);
    for (int i = 1; i < DIV_LAT; i++) dpipe[i] <= dpipe[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc <= '0;
      for (int k = 0; k < DEPTH; k++) vld[k] <= 1'b0;
    end else begin
      cyc <= (cyc == LAST) ? '0 : cyc + 1'b1;
      if (cyc == LAST) begin
        vld[0] <= in_valid;
        for (int k = 1; k < DEPTH; k++) vld[k] <= vld[k-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (cyc == LAST) begin
      for (int i = 0; i < NV; i++) vtx[0][i] <= in_vtx[i*W +: W];
      for (int k = 1; k < DEPTH; k++) begin
        vtx[k] <= vtx[k-1];
        res[k] <= res[k-1];
        err[k] <= err[k-1];
        den[k] <= den[k-1];
        num[k] <= num[k-1];
      end
    end else begin
      for (int i = 0; i < 8; i++)
        if (cyc == CW'(i)) begin
          res[MID][i] <= dpipe[DIV_LAT-1][W-1:0];
          err[MID][i] <= dpipe[DIV_LAT-1][W];
        end
      for (int i = 8; i < NR; i++)
        if (cyc == CW'(i)) begin
          res[OLD][i] <= dpipe[DIV_LAT-1][W-1:0];
          err[OLD][i] <= dpipe[DIV_LAT-1][W];
        end
      if (cyc == CW'(2)) den[MID] <= diff;
      for (int j = 0; j < 4; j++)
        if (cyc == CW'(j + 3)) num[MID][j] <= diff;
    end
  end

  // R9
  one_out_per_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R1
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready);

  // R4
  long_div_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_err[1] == out_err[0] && out_err[7:4] == {4{out_err[0]}}));

  // R5
  grad_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_err[11:8]) == 0 || $countones(out_err[11:8]) == 4));

  for (genvar i = 0; i < NR; i++) begin : g_sat
    // R7
    sat_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_err[i]) |->
        (out_res[i*W +: W] == {1'b0, {(W-1){1'b1}}} || out_res[i*W +: W] == {1'b1, {(W-1){1'b0}}}));
  end
endmodule

// File: tb/tri_setup_test.sv
module tri_setup_test;
  localparam int CLK_PERIOD = 10;
  localparam int NTRI = 40;
  localparam int LAT  = 77;
  localparam int U    = 65536;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [575:0] in_vtx = '0;
  logic         out_valid;
  logic [383:0] out_res;
  logic [11:0]  out_err;

  tri_setup uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_vtx(in_vtx), .out_valid(out_valid), .out_res(out_res), .out_err(out_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int kc = 0;
  int checks = 0;
  int failures = 0;
  int tri_idx = 0;
  int outs = 0;
  int last_due = 0;
  bit finished = 1'b0;
  logic [31:0]  rs = 32'h1234_5678;
  logic [575:0] cur;
  logic [383:0] er;
  logic [11:0]  ee;
  int           q_due[$];
  logic [383:0] q_res[$];
  logic [11:0]  q_err[$];
  string        q_tag[$];

  always @(posedge clk) if (rst_n) kc <= kc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s got %0h exp %0h (cycle %0d)", tag, what, act, exp, kc);
    end
  endtask

  task automatic finish_up;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  function automatic logic [32:0] m_div(input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, q;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    if (sb == 0) return (sa < 0) ? {1'b1, 32'h8000_0000} : {1'b1, 32'h7fff_ffff};
    q = (sa * 65536) / sb;
    if (q > 64'sd2147483647) return {1'b0, 32'h7fff_ffff};
    if (q < -64'sd2147483648) return {1'b0, 32'h8000_0000};
    return {1'b0, q[31:0]};
  endfunction

  function automatic logic [31:0] m_mul(input logic [31:0] a, input logic [31:0] b);
    longint p;
    p = longint'($signed(a)) * longint'($signed(b));
    p = p >>> 16;
    return p[31:0];
  endfunction

  function automatic logic [31:0] gv(input logic [575:0] v, input int k, input int f);
    return v[(k*6+f)*32 +: 32];
  endfunction

  task automatic model(input logic [575:0] v, output logic [383:0] r, output logic [11:0] e);
    logic [32:0] t;
    logic [31:0] q, dn, nm, dy;
    dy = gv(v,2,1) - gv(v,0,1);
    t = m_div(gv(v,1,1) - gv(v,0,1), dy); r[0 +: 32] = t[31:0]; e[0] = t[32]; q = t[31:0];
    t = m_div(gv(v,2,0) - gv(v,0,0), dy); r[32 +: 32] = t[31:0]; e[1] = t[32];
    t = m_div(gv(v,1,0) - gv(v,0,0), gv(v,1,1) - gv(v,0,1)); r[64 +: 32] = t[31:0]; e[2] = t[32];
    t = m_div(gv(v,2,0) - gv(v,1,0), gv(v,2,1) - gv(v,1,1)); r[96 +: 32] = t[31:0]; e[3] = t[32];
    dn = gv(v,1,0) - gv(v,0,0) - m_mul(gv(v,2,0) - gv(v,0,0), q);
    for (int c = 2; c < 6; c++) begin
      t = m_div(gv(v,2,c) - gv(v,0,c), dy);
      r[(c+2)*32 +: 32] = t[31:0]; e[c+2] = t[32];
      nm = gv(v,1,c) - gv(v,0,c) - m_mul(gv(v,2,c) - gv(v,0,c), q);
      t = m_div(nm, dn);
      r[(c+6)*32 +: 32] = t[31:0]; e[c+6] = t[32];
    end
  endtask

  function automatic logic [575:0] mk(input int x0, input int y0, input int x1,
                                      input int y1, input int x2, input int y2);
    logic [575:0] v;
    int p [18];
    p = '{x0, y0, 1*U, 10*U, 200*U, -5*U,
          x1, y1, 3*U, 20*U, 100*U,  5*U,
          x2, y2, 7*U, 30*U,   0*U, 50*U};
    for (int i = 0; i < 18; i++) v[i*32 +: 32] = p[i];
    return v;
  endfunction

  task automatic next_rand;
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
  endtask

  task automatic gen(input int n, output logic [575:0] v);
    case (n)
      0: v = mk(0, 0, 10*U, 5*U, 3*U, 20*U);
      1: v = mk(0, 0, 8*U, 0, 4*U, 16*U);        // R7 upper edge has zero height
      2: v = mk(0, 4*U, 5*U, 4*U, 9*U, 4*U);     // R7 all heights zero
      3: v = mk(0, 0, 2*U, 4*U, 4*U, 8*U);       // R7 collinear, shared denominator zero
      4: v = mk(0, 0, 5*U, 1, 30000*U, 2);       // R6 quotient clamps
      5: v = mk(0, 0, U, U, -1, 3*U);            // R6 rounds toward zero
      default: for (int i = 0; i < 18; i++) begin
        next_rand();
        v[i*32 +: 32] = {{8{rs[23]}}, rs[23:0]};
      end
    endcase
  endtask

  function automatic string tag_of(input int n);
    if (n >= 1 && n <= 3) return "R7";
    if (n == 4 || n == 5) return "R6";
    return "R2";
  endfunction

  function automatic string field_tag(input int i);
    if (i >= 1 && i <= 3) return "R3";
    if (i >= 8) return "R5";
    return "R4";
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL R8 watchdog expired got 0 exp 1");
    finish_up();
  end

  initial begin : main
    gen(0, cur);
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R11", "out_valid in reset", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b0, "R11", "in_ready in reset", 64'(in_ready), 64'd0);
    rst_n = 1'b1;
    while (!finished) begin
      @(negedge clk);
      chk(in_ready == ((kc % 16) == 15), (kc < 16) ? "R11" : "R1", "in_ready",
          64'(in_ready), 64'((kc % 16) == 15));
      begin
        bit ev;
        ev = (q_due.size() > 0) && (q_due[0] == kc);
        chk(out_valid == ev, ev ? "R8" : "R10", "out_valid", 64'(out_valid), 64'(ev));
        if (ev) begin
          if (out_valid) begin
            outs++;
            for (int i = 0; i < 12; i++)
              chk(out_res[i*32 +: 32] == q_res[0][i*32 +: 32], field_tag(i),
                  $sformatf("result %0d (%s)", i, q_tag[0]),
                  64'(out_res[i*32 +: 32]), 64'(q_res[0][i*32 +: 32]));
            chk(out_err == q_err[0], "R7", $sformatf("error flags (%s)", q_tag[0]),
                64'(out_err), 64'(q_err[0]));
          end
          void'(q_due.pop_front());
          void'(q_res.pop_front());
          void'(q_err.pop_front());
          void'(q_tag.pop_front());
        end
      end
      in_valid = (((kc / 16) % 5) != 3) && (tri_idx < NTRI);
      if (in_valid) in_vtx = cur;
      else begin
        for (int i = 0; i < 18; i++) begin next_rand(); in_vtx[i*32 +: 32] = rs; end  // R10 ignored data
      end
      if (in_valid && in_ready) begin
        model(cur, er, ee);
        q_due.push_back(kc + LAT);
        q_res.push_back(er);
        q_err.push_back(ee);
        q_tag.push_back(tag_of(tri_idx));
        last_due = kc + LAT;
        tri_idx++;
        gen(tri_idx, cur);
      end
      if (tri_idx == NTRI && q_due.size() == 0 && kc > last_due + 20) finished = 1'b1;
    end
    chk(outs == NTRI, "R9", "output count", 64'(outs), 64'(NTRI));
    finish_up();
  end
endmodule